// File: doc/BRIEF.md
# Daisy-Chained ADC Readout Sequencer

This block paces a chain of simultaneous-sampling converters that share one serial link. A programmable period counter issues a one-cycle conversion-start pulse. The converters then hold a busy line high while they convert. When that line falls, the block becomes the serial master. It drives the chip select low and shifts out zero dummy bits. For each result word it produces sixteen serial clocks, and it captures the returned bits most significant first.

The chain always returns channel zero first. Every channel below the highest requested one therefore has to be read as well. The time a readout takes grows with the highest channel requested.

Each captured word appears on a word stream tagged with its channel. The word is also written into one half of a two-half packet store. When a half fills, a one-cycle packet strobe names that half, and writing moves on to the other half. The consumer reads the finished half by word address and frees it with a release pulse. The half that has been full the longest is always the one freed first. When the half due to be filled next is still full, the block runs out of space and conversion-start pulses stop. A start pulse that arrives while a readout is still under way is an overrun, and so is a word that finds no free space. Either one sets a sticky flag.

Top module: `adc_chain_reader`

## Requirements
- R1: While reset is asserted and on the first cycle after it, chip select is high, the serial clock is at its idle level, the conversion-start output is low, and the overrun flag and packet strobe are low.
- R2: While enabled, the conversion-start output pulses for one cycle every `cfg_period` clock cycles.
- R3: While `cfg_enable` is low, no conversion-start pulse is issued.
- R4: Chip select goes low only after `busy` falls following an accepted start pulse. It never goes low while `busy` is still high for that conversion.
- R5: The data output to the converters is 0 throughout every readout, and chip select stays low without a break for the whole readout.
- R6: One readout delivers words for channels 0 up to `cfg_top_ch` in ascending order on `word_valid`, `word_ch` and `word_data`. Each word is assembled most significant bit first. With the default mode (idle-low clock, sample on the first edge), a bit is sampled on the rising serial-clock edge, and the converters change their output on the falling edge.
- R7: A readout of N words gives exactly 16·N serial-clock pulses. The serial clock rests at its idle level whenever chip select is high.
- R8: A `cfg_top_ch` above MAX_CH-1 is treated as MAX_CH-1.
- R9: Every PKT_WORDS stored words raise `pkt_ready` for one cycle, with `pkt_half` naming the half just filled. Half 0 fills first and the halves alternate. `rd_data` returns the word at position `rd_addr`, in arrival order, of the oldest full half.
- R10: A start pulse that arrives while a readout is pending or in progress sets `overrun`. That pulse neither restarts nor extends the current readout. `overrun` stays set until `ovr_clear` is pulsed.
- R11: While the half due to be filled next is full, no conversion-start pulse is issued. A `pkt_release` frees the oldest full half, and start pulses then resume.
- R12: A word captured while no half is free is discarded and sets `overrun`. It still appears on the word stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Run the sampling period counter |
| cfg_period | input | PERIOD_W | Cycles between conversion starts |
| cfg_top_ch | input | CH_W | Highest channel to read |
| ovr_clear | input | 1 | Clears the overrun flag |
| pkt_release | input | 1 | Frees the oldest full packet half |
| rd_addr | input | AW | Word address within the oldest full half |
| busy | input | 1 | Converter busy, high while converting |
| spi_miso | input | 1 | Serial data from the converter chain |
| conv_start | output | 1 | One-cycle conversion-start pulse |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the converters (zeros) |
| spi_cs_n | output | 1 | Active-low chip select |
| word_valid | output | 1 | One-cycle strobe for a captured word |
| word_data | output | WORD_W | Captured word |
| word_ch | output | CH_W | Channel of the captured word |
| pkt_ready | output | 1 | One-cycle strobe when a packet half fills |
| pkt_half | output | 1 | Half that just filled |
| rd_data | output | WORD_W | Word read from the oldest full half |
| overrun | output | 1 | Sticky overrun or dropped-word flag |

## Verification
The hardest state to reach is a packet half filling in the middle of a readout while the other half is still waiting to be drained. That is the only way a word can be discarded. The stimulus reads twelve channels into eight-word halves and never releases either half. The first readout leaves four words in half 1, and the second readout fills half 1 after four words. The remaining eight words then find no free space. The conversion-start pulse for the next readout must also be withheld, which the bench checks by watching the start line for several periods.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_WAIT = 2'd1,
      SEQ_READ = 2'd2
   } seq_state_t;
endpackage

// File: rtl/adc_rate_timer.sv
module adc_rate_timer #(
   parameter int PERIOD_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic [PERIOD_W-1:0] period,
   output logic                tick
);
   logic [PERIOD_W-1:0] cnt;
   logic                wrap;

   assign wrap = ({1'b0, cnt} + 1'b1) >= {1'b0, period};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (!en) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (wrap) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end

   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && en && period > 1) |=> !tick); // R2
   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !tick); // R3
endmodule

// File: rtl/adc_spi_reader.sv
module adc_spi_reader #(
   parameter int WORD_W = 16,
   parameter int MAX_CH = 12,
   parameter int HALF   = 2,
   parameter int CPOL   = 0,
   parameter int CPHA   = 0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       go,
   input  logic [$clog2(MAX_CH):0]    n_words,
   input  logic                       miso,
   output logic                       sclk,
   output logic                       cs_n,
   output logic                       mosi,
   output logic                       word_valid,
   output logic [WORD_W-1:0]          word_data,
   output logic [$clog2(MAX_CH)-1:0]  word_idx,
   output logic                       done
);
   localparam int CH_W = $clog2(MAX_CH);
   localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;
   localparam int BW   = $clog2(WORD_W);
   localparam int EW   = $clog2(MAX_CH * WORD_W + 1);

   logic              active;
   logic              ph;
   logic              samp;
   logic [HW-1:0]     hcnt;
   logic [BW-1:0]     bitc;
   logic [CH_W-1:0]   wcnt;
   logic [EW-1:0]     edges;
   logic [WORD_W-1:0] shreg;

   generate
      if (CPHA == 0) begin : g_lead
         assign samp = ~ph;
      end else begin : g_trail
         assign samp = ph;
      end
   endgenerate

   assign sclk = ph ^ (CPOL != 0);
   assign cs_n = ~active;
   assign mosi = 1'b0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active     <= 1'b0;
         ph         <= 1'b0;
         hcnt       <= '0;
         bitc       <= '0;
         wcnt       <= '0;
         edges      <= '0;
         shreg      <= '0;
         word_valid <= 1'b0;
         word_data  <= '0;
         word_idx   <= '0;
         done       <= 1'b0;
      end else begin
         word_valid <= 1'b0;
         done       <= 1'b0;
         if (go && !active) begin
            active <= 1'b1;
            ph     <= 1'b0;
            hcnt   <= '0;
            bitc   <= '0;
            wcnt   <= '0;
            edges  <= EW'(n_words) * EW'(WORD_W);
         end else if (active) begin
            if (hcnt == HW'(HALF - 1)) begin
               hcnt <= '0;
               ph   <= ~ph;
               if (samp) begin
                  shreg <= {shreg[WORD_W-2:0], miso};
                  if (bitc == BW'(WORD_W - 1)) begin
                     bitc       <= '0;
                     word_valid <= 1'b1;
                     word_data  <= {shreg[WORD_W-2:0], miso};
                     word_idx   <= wcnt;
                     wcnt       <= wcnt + 1'b1;
                  end else begin
                     bitc <= bitc + 1'b1;
                  end
               end
               if (ph) begin
                  edges <= edges - 1'b1;
                  if (edges == EW'(1)) begin
                     active <= 1'b0;
                     done   <= 1'b1;
                  end
               end
            end else begin
               hcnt <= hcnt + 1'b1;
            end
         end
      end
   end

   AST_IDLE_CLOCK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (sclk == (CPOL != 0))); // R7
   AST_DONE_ENDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cs_n); // R5
endmodule

// File: rtl/adc_pingpong_buf.sv
module adc_pingpong_buf #(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [WORD_W-1:0]        wr_data,
   input  logic                     rel,
   input  logic [$clog2(DEPTH)-1:0] rd_addr,
   output logic [WORD_W-1:0]        rd_data,
   output logic                     pkt_ready,
   output logic                     pkt_half,
   output logic                     fill_full,
   output logic                     drop
);
   localparam int AW = $clog2(DEPTH);
   localparam int MW = $clog2(2 * DEPTH);

   logic [WORD_W-1:0] mem [2*DEPTH];
   logic [AW-1:0]     wr_ptr;
   logic              fill_sel;
   logic              drain_sel;
   logic [1:0]        full;
   logic [MW-1:0]     wr_loc;
   logic [MW-1:0]     rd_loc;

   assign fill_full = full[fill_sel];
   assign drop      = wr_en & full[fill_sel];
   assign wr_loc    = (fill_sel ? MW'(DEPTH) : MW'(0)) + MW'(wr_ptr);
   assign rd_loc    = (drain_sel ? MW'(DEPTH) : MW'(0)) + MW'(rd_addr);
   assign rd_data   = (32'(rd_addr) < DEPTH) ? mem[rd_loc] : '0;

   always_ff @(posedge clk) begin
      if (wr_en && !full[fill_sel]) mem[wr_loc] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr    <= '0;
         fill_sel  <= 1'b0;
         drain_sel <= 1'b0;
         full      <= '0;
         pkt_ready <= 1'b0;
         pkt_half  <= 1'b0;
      end else begin
         pkt_ready <= 1'b0;
         if (wr_en && !full[fill_sel]) begin
            if (wr_ptr == AW'(DEPTH - 1)) begin
               wr_ptr         <= '0;
               full[fill_sel] <= 1'b1;
               fill_sel       <= ~fill_sel;
               pkt_ready      <= 1'b1;
               pkt_half       <= fill_sel;
            end else begin
               wr_ptr <= wr_ptr + 1'b1;
            end
         end
         if (rel && full[drain_sel]) begin
            full[drain_sel] <= 1'b0;
            drain_sel       <= ~drain_sel;
         end
      end
   end

   generate
      for (genvar h = 0; h < 2; h++) begin : g_hold
         AST_FULL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (full[h] && !(rel && drain_sel == 1'(h))) |=> full[h]); // R11
      end
   endgenerate
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_ready |=> !pkt_ready || DEPTH == 1); // R9
endmodule

// File: rtl/adc_chain_reader.sv
module adc_chain_reader #(
   parameter int WORD_W    = 16,
   parameter int MAX_CH    = 12,
   parameter int PERIOD_W  = 16,
   parameter int PKT_WORDS = 8,
   parameter int SCLK_HALF = 2,
   parameter int CPOL      = 0,
   parameter int CPHA      = 0,
   localparam int CH_W     = $clog2(MAX_CH),
   localparam int AW       = $clog2(PKT_WORDS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_enable,
   input  logic [PERIOD_W-1:0] cfg_period,
   input  logic [CH_W-1:0]     cfg_top_ch,
   input  logic                ovr_clear,
   input  logic                pkt_release,
   input  logic [AW-1:0]       rd_addr,
   input  logic                busy,
   input  logic                spi_miso,
   output logic                conv_start,
   output logic                spi_sclk,
   output logic                spi_mosi,
   output logic                spi_cs_n,
   output logic                word_valid,
   output logic [WORD_W-1:0]   word_data,
   output logic [CH_W-1:0]     word_ch,
   output logic                pkt_ready,
   output logic                pkt_half,
   output logic [WORD_W-1:0]   rd_data,
   output logic                overrun
);
   import adc_seq_pkg::*;

   if (WORD_W < 2)     begin : g_bad_word  $error("WORD_W must be at least 2"); end
   if (MAX_CH < 2)     begin : g_bad_ch    $error("MAX_CH must be at least 2"); end
   if (PKT_WORDS < 2)  begin : g_bad_pkt   $error("PKT_WORDS must be at least 2"); end
   if (SCLK_HALF < 1)  begin : g_bad_half  $error("SCLK_HALF must be at least 1"); end
   if (CPOL > 1 || CPHA > 1) begin : g_bad_mode $error("CPOL and CPHA are single bits"); end

   seq_state_t      state;
   logic            tick;
   logic            fill_full;
   logic            drop;
   logic            busy_q;
   logic            busy_fell;
   logic            go;
   logic            rd_done;
   logic [CH_W-1:0] top_clamped;
   logic [CH_W-1:0] hi_q;

   assign top_clamped = (32'(cfg_top_ch) > MAX_CH - 1) ? CH_W'(MAX_CH - 1) : cfg_top_ch;
   assign conv_start  = tick & ~fill_full;
   assign busy_fell   = busy_q & ~busy;
   assign go          = (state == SEQ_WAIT) & busy_fell;

   adc_rate_timer #(.PERIOD_W(PERIOD_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .en(cfg_enable), .period(cfg_period), .tick(tick)
   );

   adc_spi_reader #(
      .WORD_W(WORD_W), .MAX_CH(MAX_CH), .HALF(SCLK_HALF), .CPOL(CPOL), .CPHA(CPHA)
   ) u_spi (
      .clk(clk), .rst_n(rst_n), .go(go), .n_words({1'b0, hi_q} + 1'b1),
      .miso(spi_miso), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
      .word_valid(word_valid), .word_data(word_data), .word_idx(word_ch), .done(rd_done)
   );

   adc_pingpong_buf #(.WORD_W(WORD_W), .DEPTH(PKT_WORDS)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr_en(word_valid), .wr_data(word_data),
      .rel(pkt_release), .rd_addr(rd_addr), .rd_data(rd_data),
      .pkt_ready(pkt_ready), .pkt_half(pkt_half), .fill_full(fill_full), .drop(drop)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= SEQ_IDLE;
         busy_q  <= 1'b0;
         hi_q    <= '0;
         overrun <= 1'b0;
      end else begin
         busy_q <= busy;
         if ((conv_start && state != SEQ_IDLE) || drop) overrun <= 1'b1;
         else if (ovr_clear)                            overrun <= 1'b0;
         case (state)
            SEQ_IDLE: if (conv_start) begin
               state <= SEQ_WAIT;
               hi_q  <= top_clamped;
            end
            SEQ_WAIT: if (busy_fell) state <= SEQ_READ;
            SEQ_READ: if (rd_done)   state <= SEQ_IDLE;
            default:                 state <= SEQ_IDLE;
         endcase
      end
   end

   AST_READ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> ($past(busy, 2) && !$past(busy))); // R4
   AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !ovr_clear) |=> overrun); // R10
   AST_CHANNEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> (32'(word_ch) < MAX_CH)); // R8
   AST_NO_START_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      fill_full |-> !conv_start); // R11
endmodule

// File: tb/adc_chain_reader_test.sv
module adc_chain_reader_test;
   localparam int MAX_CH = 12;
   localparam int CH_W   = 4;
   localparam int AW     = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_enable = 1'b0;
   logic [15:0] cfg_period = 16'd100;
   logic [CH_W-1:0] cfg_top_ch = '0;
   logic ovr_clear = 1'b0;
   logic pkt_release = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic busy = 1'b0;
   logic spi_miso;
   logic conv_start, spi_sclk, spi_mosi, spi_cs_n, word_valid, pkt_ready, pkt_half, overrun;
   logic [15:0] word_data, rd_data;
   logic [CH_W-1:0] word_ch;

   int vectors = 0, misses = 0;
   int frame_no = 0, frame_lat = 0, bcnt = 0;
   int nfall = 0, base = 0;
   int rx_n = 0, sclk_rises = 0, mosi_bad = 0, cs_falls = 0, pkt_cnt = 0, starts = 0;
   logic [15:0] rx_d [64];
   logic [CH_W-1:0] rx_c [64];
   logic last_half = 1'b0;

   always #5 clk = ~clk;

   adc_chain_reader uut (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_period(cfg_period),
      .cfg_top_ch(cfg_top_ch), .ovr_clear(ovr_clear), .pkt_release(pkt_release),
      .rd_addr(rd_addr), .busy(busy), .spi_miso(spi_miso), .conv_start(conv_start),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
      .word_valid(word_valid), .word_data(word_data), .word_ch(word_ch),
      .pkt_ready(pkt_ready), .pkt_half(pkt_half), .rd_data(rd_data), .overrun(overrun)
   );

   function automatic logic [15:0] sample_val(int f, int ch);
      return {8'(f * 37 + 11), 4'h5, 4'(ch)};
   endfunction

   function automatic logic slave_bit(int f, int k);
      logic [15:0] w;
      w = sample_val(f, k / 16);
      return w[15 - (k % 16)];
   endfunction

   // converter model: busy for 20 cycles after each start pulse
   always @(negedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         bcnt = 0;
      end else if (conv_start) begin
         busy <= 1'b1;
         bcnt = 20;
         frame_no++;
         starts++;
      end else if (bcnt > 0) begin
         bcnt--;
         if (bcnt == 0) busy <= 1'b0;
      end
   end
   always @(negedge spi_cs_n) begin
      base = nfall;
      frame_lat = frame_no;
      cs_falls++;
   end
   always @(negedge spi_sclk) nfall++;
   always @(posedge spi_sclk) if (!spi_cs_n) sclk_rises++;
   assign spi_miso = (!spi_cs_n && (nfall - base) < 16 * MAX_CH) ? slave_bit(frame_lat, nfall - base) : 1'b0;

   always @(negedge clk) begin
      if (rst_n && word_valid) begin
         if (rx_n < 64) begin
            rx_d[rx_n] = word_data;
            rx_c[rx_n] = word_ch;
         end
         rx_n++;
      end
      if (rst_n && !spi_cs_n && spi_mosi) mosi_bad++;
      if (rst_n && pkt_ready) begin
         pkt_cnt++;
         last_half = pkt_half;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         misses++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      cfg_enable = 1'b0;
      ovr_clear = 1'b0;
      pkt_release = 1'b0;
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic run_frame(output int nw, output int nr, output int w0, output int fl);
      int t = 0;
      int r0;
      while (spi_cs_n && t < 20000) begin @(negedge clk); t++; end
      w0 = rx_n;
      r0 = sclk_rises;
      fl = frame_lat;
      while (!spi_cs_n && t < 20000) begin @(negedge clk); t++; end
      nw = rx_n - w0;
      nr = sclk_rises - r0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 select/clock idle", {spi_cs_n, spi_sclk}, 2);
      check(!conv_start && !overrun && !pkt_ready, "R1 outputs low", {conv_start, overrun, pkt_ready}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(spi_cs_n && !conv_start && !overrun, "R1 first cycle", {spi_cs_n, conv_start, overrun}, 4);
   endtask

   task automatic t_period();
      int t = 0, gap = 0;
      do_reset();
      cfg_period = 16'd50;
      cfg_top_ch = 4'd0;
      cfg_enable = 1'b1;
      while (!conv_start && t < 1000) begin @(negedge clk); t++; end
      @(negedge clk);
      gap = 1;
      while (!conv_start && gap < 1000) begin @(negedge clk); gap++; end
      check(gap == 50, "R2 start spacing", gap, 50);
      cfg_enable = 1'b0;
      repeat (30) @(negedge clk);
      t = starts;
      repeat (300) @(negedge clk);
      check(starts == t, "R3 no start when disabled", starts - t, 0);
   endtask

   task automatic t_frame(input logic [CH_W-1:0] top, input int exp_n, input string tag);
      int nw, nr, w0, fl, t = 0;
      bit cs_early = 0;
      bit order_ok = 1;
      do_reset();
      cfg_period = 16'd1500;
      cfg_top_ch = top;
      cfg_enable = 1'b1;
      while (!conv_start && t < 3000) begin @(negedge clk); t++; end
      @(negedge clk);
      while (busy && t < 3000) begin
         if (!spi_cs_n) cs_early = 1;
         @(negedge clk);
         t++;
      end
      check(!cs_early, "R4 select held until busy falls", cs_early, 0);
      run_frame(nw, nr, w0, fl);
      cfg_enable = 1'b0;
      check(nw == exp_n, tag, nw, exp_n);
      check(nr == 16 * exp_n, "R7 clocks per readout", nr, 16 * exp_n);
      for (int k = 0; k < nw && w0 + k < 64; k++) begin
         if (rx_c[w0 + k] != CH_W'(k) || rx_d[w0 + k] != sample_val(fl, k)) order_ok = 0;
      end
      check(order_ok, "R6 channel order and data", order_ok, 1);
      check(mosi_bad == 0, "R5 dummy output zero", mosi_bad, 0);
      check(spi_sclk == 1'b0, "R7 clock idle after readout", spi_sclk, 0);
   endtask

   task automatic t_packet();
      int nw, nr, w0, w1, fl;
      bit ok = 1;
      do_reset();
      cfg_period = 16'd400;
      cfg_top_ch = 4'd3;
      cfg_enable = 1'b1;
      pkt_cnt = 0;
      run_frame(nw, nr, w0, fl);
      check(pkt_cnt == 0, "R9 no packet after 4 words", pkt_cnt, 0);
      run_frame(nw, nr, w1, fl);
      cfg_enable = 1'b0;
      repeat (5) @(negedge clk);
      check(pkt_cnt == 1 && last_half == 1'b0, "R9 first packet in half 0", pkt_cnt * 2 + int'(last_half), 2);
      for (int a = 0; a < 8; a++) begin
         rd_addr = AW'(a);
         #1;
         if (rd_data != rx_d[w0 + a]) ok = 0;
         @(negedge clk);
      end
      check(ok, "R9 packet contents by address", ok, 1);
   endtask

   task automatic t_overrun();
      int nw, nr, w0, fl, t = 0;
      do_reset();
      cfg_period = 16'd300;
      cfg_top_ch = 4'd11;
      cfg_enable = 1'b1;
      run_frame(nw, nr, w0, fl);
      cfg_enable = 1'b0;
      check(overrun == 1'b1, "R10 overrun on early start", overrun, 1);
      check(nw == 12, "R10 readout not restarted", nw, 12);
      while (!spi_cs_n && t < 3000) begin @(negedge clk); t++; end
      repeat (100) @(negedge clk);
      check(overrun == 1'b1, "R10 overrun held", overrun, 1);
      ovr_clear = 1'b1;
      @(negedge clk);
      ovr_clear = 1'b0;
      @(negedge clk);
      check(overrun == 1'b0, "R10 overrun cleared", overrun, 0);
   endtask

   task automatic t_space();
      int t = 0, s0, c0;
      do_reset();
      cfg_period = 16'd400;
      cfg_top_ch = 4'd3;
      cfg_enable = 1'b1;
      pkt_cnt = 0;
      while (pkt_cnt < 2 && t < 20000) begin @(negedge clk); t++; end
      while (!spi_cs_n && t < 20000) begin @(negedge clk); t++; end
      s0 = starts;
      c0 = cs_falls;
      repeat (1600) @(negedge clk);
      check(starts == s0 && cs_falls == c0, "R11 starts withheld when full", starts - s0, 0);
      check(overrun == 1'b0, "R11 no overrun while withheld", overrun, 0);
      pkt_release = 1'b1;
      @(negedge clk);
      pkt_release = 1'b0;
      t = 0;
      while (cs_falls == c0 && t < 2000) begin @(negedge clk); t++; end
      cfg_enable = 1'b0;
      check(cs_falls > c0, "R11 sampling resumes after release", cs_falls - c0, 1);
   endtask

   task automatic t_drop();
      int nw, nr, w0, fl, s0;
      do_reset();
      cfg_period = 16'd1200;
      cfg_top_ch = 4'd11;
      cfg_enable = 1'b1;
      pkt_cnt = 0;
      run_frame(nw, nr, w0, fl);
      check(overrun == 1'b0, "R12 no overrun while space remains", overrun, 0);
      run_frame(nw, nr, w0, fl);
      s0 = starts;
      repeat (2500) @(negedge clk);
      cfg_enable = 1'b0;
      check(nw == 12, "R12 dropped words still streamed", nw, 12);
      check(overrun == 1'b1, "R12 overrun on dropped words", overrun, 1);
      check(pkt_cnt == 2 && last_half == 1'b1, "R12 two packets only", pkt_cnt, 2);
      check(starts == s0, "R12 start withheld after drop", starts - s0, 0);
   endtask

   initial begin
      #2000000;
      misses++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      t_reset();
      t_period();
      t_frame(4'd5, 6, "R6 six words for top channel 5");
      t_frame(4'd15, 12, "R8 clamped to twelve words");
      t_packet();
      t_overrun();
      t_space();
      t_drop();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule